// File: doc/BRIEF.md
# Sticky Status and Interrupt Control Register Set

This block holds the status and control bytes of a timekeeping device. Hardware event inputs report four conditions: a power-up after both supplies were lost, entry into battery backup, an alarm match, and a missing oscillator. Each event sets a sticky flag that stays set until it is cleared. The host reaches three byte registers through a simple strobe interface: a status register, an oscillator-fail register and an interrupt control register. A write of 0 clears a flag. A write of 1 never sets one.

The status register can clear its battery and alarm flags by itself once a read of it completes. The serial bus logic marks the start of a read with a start pulse and signals a valid STOP with a read-done pulse. Any event that arrives between those two pulses is recorded, and the auto-clear leaves that flag set, so the host does not lose the event. The interrupt control register drives the alarm enable and low-power select outputs. A seal bit in the status register drives an output to the power-control logic.

Top module: `sscr_top`

## Requirements
- R1: After reset the status register (host address 0xB) reads 0x00, the interrupt control register (0x8) reads 0x00, and the oscillator-fail register (0x9) reads 0x80. The outputs alarm_en, lowpwr_mode and seal_out are 0.
- R2: Status bit 0 (clock fail) is set one cycle after evt_pwr_lost is high. A host write to the status register does not change it. It clears one cycle after clk_reg_wr is high.
- R3: Status bit 1 (battery) is set one cycle after evt_batt_entry is high. A status write with bit 1 = 0 clears it. A status write with bit 1 = 1 does not set it.
- R4: Status bit 2 (alarm) is set one cycle after evt_alarm_match is high, but only while alarm_en is 1. A status write with bit 2 = 0 clears it. A status write with bit 2 = 1 does not set it.
- R5: Status bit 7 (auto-clear enable) is read/write. When it is 1, a read_done pulse that ends a read started on the status register clears bits 1 and 2. When it is 0, that read leaves both bits unchanged.
- R6: An alarm or battery event that arrives on any cycle from rd_start through rd_done of a status read survives the auto-clear. That flag reads 1 after the read.
- R7: Oscillator-fail register bit 7 is set while osc_absent is high. A write of 0 clears it only while osc_absent is low. A write of 1 has no effect.
- R8: Interrupt control bit 6 drives alarm_en and bit 5 drives lowpwr_mode. Both are read/write. All other bits of that register, bits 6, 4 and 3 of the status register and bits 6..0 of the oscillator-fail register read 0.
- R9: Status bit 5 (seal) is read/write and drives seal_out.
- R10: A read started on a register other than the status register does not auto-clear any flag.
- R11: When a set event and a clearing write hit a flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| evt_pwr_lost | input | 1 | Power-up after total loss, one-cycle pulse |
| evt_batt_entry | input | 1 | Battery backup entered, pulse |
| evt_alarm_match | input | 1 | Alarm comparator match, pulse |
| osc_absent | input | 1 | Oscillator missing, level |
| clk_reg_wr | input | 1 | Valid write to timekeeping section, pulse |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| rd_start | input | 1 | Host read of host_addr begins |
| rd_done | input | 1 | Read ended by valid STOP |
| host_rdata | output | 8 | Read data of host_addr, combinational |
| alarm_en | output | 1 | Alarm enable |
| lowpwr_mode | output | 1 | Low-power mode select |
| seal_out | output | 1 | Battery-saver seal to power control |

## Verification
Every flag and control bit sits one register away from its cause. An event, write or read-done applied before a clock edge appears on host_rdata and the outputs after that edge. The bench drives inputs on the falling edge and samples one full cycle later. It sets host_addr and waits a short settling delay before each comparison, because the read path is combinational. For the read-window cases, events are placed on the rd_start cycle, on the cycles between the pulses and on the rd_done cycle itself. The flags are compared on the cycle after rd_done.

// File: rtl/sscr_pkg.sv
package sscr_pkg;
   // Status register bit positions (host decodes these)
   localparam int ST_CKFAIL = 0;
   localparam int ST_BATT   = 1;
   localparam int ST_ALARM  = 2;
   localparam int ST_SEAL   = 5;
   localparam int ST_ARST   = 7;
   // Oscillator-fail register
   localparam int OF_FLAG   = 7;
   // Interrupt control register
   localparam int IC_LPM    = 5;
   localparam int IC_ALME   = 6;
   // Index of the auto-clearable flags
   localparam int AC_BATT   = 0;
   localparam int AC_ALARM  = 1;
   localparam int N_AC      = 2;
endpackage

// File: rtl/sscr_sticky_bit.sv
module sscr_sticky_bit #(
   parameter bit RST_VAL     = 1'b0,
   parameter bit HAS_AUTOCLR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wclr_i,
   input  logic aclr_i,
   input  logic spare_i,
   output logic q
);
   logic aclr_eff;

   generate
      if (HAS_AUTOCLR) begin : g_ac
         assign aclr_eff = aclr_i & ~spare_i;
      end else begin : g_noac
         assign aclr_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST_VAL;
      else if (set_i)   q <= 1'b1;
      else if (wclr_i)  q <= 1'b0;
      else if (aclr_eff) q <= 1'b0;
   end

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);

   // R3
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !set_i) |=> !q);
endmodule

// File: rtl/sscr_rd_track.sv
module sscr_rd_track #(
   parameter int N_EVT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_start,
   input  logic             rd_done,
   input  logic             addr_hit,
   input  logic [N_EVT-1:0] evt,
   output logic             aclr_pulse,
   output logic [N_EVT-1:0] spare
);
   initial begin
      if (N_EVT < 1) $error("N_EVT must be at least 1");
   end

   logic             rd_live;
   logic [N_EVT-1:0] hits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_live <= 1'b0;
         hits    <= '0;
      end else if (rd_done) begin
         rd_live <= 1'b0;
         hits    <= '0;
      end else if (rd_start) begin
         rd_live <= addr_hit;
         hits    <= evt;
      end else if (rd_live) begin
         hits    <= hits | evt;
      end
   end

   assign aclr_pulse = rd_done & rd_live;
   assign spare      = hits | evt;

   // R10
   window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_live);

   // R6
   hit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_live && !rd_done && !rd_start && evt != '0) |=> (hits & $past(evt)) == $past(evt));
endmodule

// File: rtl/sscr_ctrl_regs.sv
module sscr_ctrl_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic              wr_intc,
   input  logic [DATA_W-1:0] wdata,
   output logic              arst,
   output logic              seal,
   output logic              alme,
   output logic              lpm
);
   import sscr_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arst <= 1'b0;
         seal <= 1'b0;
      end else if (wr_stat) begin
         arst <= wdata[ST_ARST];
         seal <= wdata[ST_SEAL];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alme <= 1'b0;
         lpm  <= 1'b0;
      end else if (wr_intc) begin
         alme <= wdata[IC_ALME];
         lpm  <= wdata[IC_LPM];
      end
   end

   // R9
   seal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> $stable(seal));

   // R8
   alme_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_intc |=> $stable(alme) && $stable(lpm));
endmodule

// File: rtl/sscr_top.sv
module sscr_top #(
   parameter int          ADDR_W    = 4,
   parameter int          DATA_W    = 8,
   parameter logic [3:0]  ADDR_STAT = 4'hB,
   parameter logic [3:0]  ADDR_OSCF = 4'h9,
   parameter logic [3:0]  ADDR_INTC = 4'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_pwr_lost,
   input  logic              evt_batt_entry,
   input  logic              evt_alarm_match,
   input  logic              osc_absent,
   input  logic              clk_reg_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              rd_start,
   input  logic              rd_done,
   output logic [DATA_W-1:0] host_rdata,
   output logic              alarm_en,
   output logic              lowpwr_mode,
   output logic              seal_out
);
   import sscr_pkg::*;

   localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADDR_STAT);
   localparam logic [ADDR_W-1:0] A_OF = ADDR_W'(ADDR_OSCF);
   localparam logic [ADDR_W-1:0] A_IC = ADDR_W'(ADDR_INTC);

   initial begin
      if (DATA_W != 8) $error("DATA_W must be 8");
      if (ADDR_W < 4) $error("ADDR_W too small for register addresses");
      if (A_ST == A_OF || A_ST == A_IC || A_OF == A_IC)
         $error("register addresses must differ");
   end

   logic wr_st, wr_of, wr_ic;
   assign wr_st = host_wr && (host_addr == A_ST);
   assign wr_of = host_wr && (host_addr == A_OF);
   assign wr_ic = host_wr && (host_addr == A_IC);

   logic arst_q, seal_q;

   sscr_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stat (wr_st),
      .wr_intc (wr_ic),
      .wdata   (host_wdata),
      .arst    (arst_q),
      .seal    (seal_q),
      .alme    (alarm_en),
      .lpm     (lowpwr_mode)
   );
   assign seal_out = seal_q;

   // Auto-clearable flags: battery and alarm
   logic [N_AC-1:0] ac_set, ac_wclr, ac_spare, ac_q;
   logic            aclr;

   assign ac_set[AC_BATT]   = evt_batt_entry;
   assign ac_set[AC_ALARM]  = evt_alarm_match & alarm_en;
   assign ac_wclr[AC_BATT]  = wr_st & ~host_wdata[ST_BATT];
   assign ac_wclr[AC_ALARM] = wr_st & ~host_wdata[ST_ALARM];

   sscr_rd_track #(.N_EVT(N_AC)) u_rdtrk (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_start   (rd_start),
      .rd_done    (rd_done),
      .addr_hit   (host_addr == A_ST),
      .evt        (ac_set),
      .aclr_pulse (aclr),
      .spare      (ac_spare)
   );

   generate
      for (genvar i = 0; i < N_AC; i++) begin : g_acf
         sscr_sticky_bit #(.RST_VAL(1'b0), .HAS_AUTOCLR(1'b1)) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (ac_set[i]),
            .wclr_i  (ac_wclr[i]),
            .aclr_i  (aclr & arst_q),
            .spare_i (ac_spare[i]),
            .q       (ac_q[i])
         );
      end
   endgenerate

   logic ckfail_q, oscf_q;

   sscr_sticky_bit #(.RST_VAL(1'b0), .HAS_AUTOCLR(1'b0)) u_ckfail (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (evt_pwr_lost),
      .wclr_i  (clk_reg_wr),
      .aclr_i  (1'b0),
      .spare_i (1'b0),
      .q       (ckfail_q)
   );

   sscr_sticky_bit #(.RST_VAL(1'b1), .HAS_AUTOCLR(1'b0)) u_oscf (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (osc_absent),
      .wclr_i  (wr_of & ~host_wdata[OF_FLAG] & ~osc_absent),
      .aclr_i  (1'b0),
      .spare_i (1'b0),
      .q       (oscf_q)
   );

   always_comb begin
      host_rdata = '0;
      if (host_addr == A_ST) begin
         host_rdata[ST_ARST]   = arst_q;
         host_rdata[ST_SEAL]   = seal_q;
         host_rdata[ST_ALARM]  = ac_q[AC_ALARM];
         host_rdata[ST_BATT]   = ac_q[AC_BATT];
         host_rdata[ST_CKFAIL] = ckfail_q;
      end else if (host_addr == A_OF) begin
         host_rdata[OF_FLAG]   = oscf_q;
      end else if (host_addr == A_IC) begin
         host_rdata[IC_ALME]   = alarm_en;
         host_rdata[IC_LPM]    = lowpwr_mode;
      end
   end

   // R2
   ckfail_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ckfail_q && !clk_reg_wr) |=> ckfail_q);

   // R4
   alarm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ac_q[AC_ALARM]) |-> $past(alarm_en));

   // R5
   no_aclr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!arst_q && ac_q[AC_BATT] && !wr_st) |=> ac_q[AC_BATT]);

   // R7
   osc_missing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_absent |=> oscf_q);
endmodule

// File: tb/sscr_top_tb.sv
module sscr_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_pwr_lost = 0, evt_batt_entry = 0, evt_alarm_match = 0;
   logic       osc_absent = 0, clk_reg_wr = 0;
   logic [3:0] host_addr = 4'hB;
   logic       host_wr = 0;
   logic [7:0] host_wdata = 8'h00;
   logic       rd_start = 0, rd_done = 0;
   logic [7:0] host_rdata;
   logic       alarm_en, lowpwr_mode, seal_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sscr_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .evt_pwr_lost(evt_pwr_lost), .evt_batt_entry(evt_batt_entry),
      .evt_alarm_match(evt_alarm_match), .osc_absent(osc_absent),
      .clk_reg_wr(clk_reg_wr), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .rd_start(rd_start), .rd_done(rd_done),
      .host_rdata(host_rdata), .alarm_en(alarm_en),
      .lowpwr_mode(lowpwr_mode), .seal_out(seal_out)
   );

   // Vector: kind[31:28] addr[27:24] data[23:16] chk_addr[15:12] exp[11:4] req[3:0]
   // kind 0 write, 1 event pulse (data b0 pwr_lost, b1 batt, b2 alarm, b3 clk_reg_wr),
   // 2 read (start..done), 3 osc_absent level = data[0]
   localparam int NV = 26;
   localparam logic [31:0] VEC [NV] = '{
      32'h1B01B012, // R2 power-loss sets bit 0
      32'h0B00B012, // R2 status write leaves bit 0
      32'h1B08B002, // R2 clock write clears
      32'h1B02B023, // R3 battery entry
      32'h0B02B023, // R3 write 1 keeps
      32'h0B00B003, // R3 write 0 clears
      32'h1B04B004, // R4 alarm ignored while disabled
      32'h08408408, // R8 enable alarm
      32'h1B04B044, // R4 alarm sets
      32'h0B04B044, // R4 write 1 keeps
      32'h0B00B004, // R4 write 0 clears
      32'h1B06B065, // R5 both flags
      32'h2B00B065, // R5 read with auto-clear off
      32'h0B86B865, // R5 enable auto-clear
      32'h2B00B805, // R5 read clears flags
      32'h08608608, // R8 low-power on
      32'h08FF8608, // R8 unused bits read 0
      32'h0BF8BA08, // R8 R9 seal set, unused status bits 0
      32'h1B02BA23, // R3 battery again
      32'h2900BA2A, // R10 read of other register
      32'h09009007, // R7 clear with osc present
      32'h39019807, // R7 osc absent sets
      32'h09009807, // R7 clear blocked while absent
      32'h39009807, // R7 sticky after return
      32'h09009007, // R7 clear now works
      32'h09809007  // R7 write 1 no effect
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [3:0] a, input string req, input logic [7:0] exp);
      host_addr = a;
      #1;
      check(req, host_rdata, exp);
   endtask

   task automatic do_write(input logic [3:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1;
      tick();
      host_wr = 0;
   endtask

   task automatic do_evt(input logic [7:0] d);
      evt_pwr_lost = d[0]; evt_batt_entry = d[1];
      evt_alarm_match = d[2]; clk_reg_wr = d[3];
      tick();
      {evt_pwr_lost, evt_batt_entry, evt_alarm_match, clk_reg_wr} = '0;
   endtask

   task automatic do_read(input logic [3:0] a);
      host_addr = a; rd_start = 1;
      tick();
      rd_start = 0;
      tick();
      tick();
      rd_done = 1;
      tick();
      rd_done = 0;
   endtask

   initial begin
      #4000000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      peek(4'hB, "R1", 8'h00);
      peek(4'h8, "R1", 8'h00);
      peek(4'h9, "R1", 8'h80);
      check("R1", {5'b0, alarm_en, lowpwr_mode, seal_out}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [31:0] v;
         string rq;
         v = VEC[i];
         case (v[31:28])
            4'h0: do_write(v[27:24], v[23:16]);
            4'h1: do_evt(v[23:16]);
            4'h2: do_read(v[27:24]);
            default: begin osc_absent = v[16]; tick(); end
         endcase
         rq = $sformatf("R%0d vec%0d", v[3:0], i);
         peek(v[15:12], rq, v[11:4]);
      end

      // State now: status A2 (auto-clear, seal, battery), intc 60
      check("R8 ports", {6'b0, alarm_en, lowpwr_mode}, 8'h03);
      check("R9 port", {7'b0, seal_out}, 8'h01);

      // R6: events inside the read window survive; battery already set
      host_addr = 4'hB; rd_start = 1; evt_alarm_match = 1;
      tick();
      rd_start = 0; evt_alarm_match = 0;
      tick();
      rd_done = 1;
      tick();
      rd_done = 0;
      peek(4'hB, "R6 start-cycle alarm kept, battery cleared", 8'hA4);

      // R6: event on the rd_done cycle and between pulses
      host_addr = 4'hB; rd_start = 1;
      tick();
      rd_start = 0; evt_batt_entry = 1;
      tick();
      evt_batt_entry = 0;
      tick();
      rd_done = 1; evt_alarm_match = 1;
      tick();
      rd_done = 0; evt_alarm_match = 0;
      peek(4'hB, "R6 mid and done-cycle events kept", 8'hA6);

      do_read(4'hB);
      peek(4'hB, "R5 plain read clears", 8'hA0);

      // R11: set and clearing write in same cycle
      host_addr = 4'hB; host_wdata = 8'hA0; host_wr = 1; evt_batt_entry = 1;
      tick();
      host_wr = 0; evt_batt_entry = 0;
      peek(4'hB, "R11 set beats clear", 8'hA2);

      // R2: set beats clear for clock fail too
      evt_pwr_lost = 1; clk_reg_wr = 1;
      tick();
      evt_pwr_lost = 0; clk_reg_wr = 0;
      peek(4'hB, "R11 R2 clock fail set wins", 8'hA3);

      do_write(4'hB, 8'h80);
      check("R9 seal cleared", {7'b0, seal_out}, 8'h00);
      peek(4'hB, "R9 R2 status after write", 8'h81);

      do_write(4'h8, 8'h00);
      check("R8 ports cleared", {6'b0, alarm_en, lowpwr_mode}, 8'h00);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule